// File: doc/BRIEF.md
# Hashed Indirect Target Cache

This block predicts where an indirect branch will go. It is a set-associative table of branch targets. The set is chosen by folding several values into one index: the branch address, the global direction history, and the targets of the most recent indirect branches. The tag is taken from the branch address alone. The fetch stage presents a branch PC, the current global history, and a packed vector of recent path targets. In the same cycle it gets back a hit flag and a predicted target. On a miss, the predicted target is the next sequential instruction address.

When an indirect branch resolves as mispredicted, the update port writes the corrected target. The caller supplies the history and path values that were captured when the prediction was made. If a way in the indexed set already holds the branch's tag, only that way's target is rewritten. Otherwise a way picked by a free-running LFSR receives the new tag and target. The path history itself is kept outside this block and arrives as an input vector.

Top module: `ind_tgt_cache`

## Requirements
- R1: After reset every way is invalid. Every lookup misses, including a branch at PC 0, whose tag is zero, until a write fills that way.
- R2: The set index is the low log2(SETS) bits of a hash, built as follows:
  - Start from (PC >> SHIFT).
  - XOR in the global history when history hashing is enabled.
  - When path hashing is enabled, XOR in each path slot p as (slot_p >> (SHIFT + p*K)), where K = log2(SETS) / PATH_LEN with integer division.
  - Slot 0 occupies the lowest PC_W bits of the path vector and is the newest.
- R3: The tag is the low TAG_W bits of (PC >> SHIFT) and carries no history. Two PCs that agree in those bits and map to the same set alias. The same PC under a different history lands in a different set as a separate entry.
- R4: A lookup whose indexed set holds a valid way with a matching tag raises lk_hit and returns that way's stored target in the same cycle.
- R5: A lookup miss drives lk_hit low and lk_target = lk_pc + 2^SHIFT, wrapping at PC_W bits.
- R6: An update whose tag matches a valid way in its set rewrites only that way's target. The other ways of the set keep their entries.
- R7: An update whose tag matches no way allocates one way, chosen by an LFSR that advances on each allocation. The written branch hits afterwards. A set never holds more than WAYS distinct tags, and once a set is full it stays full.
- R8: The update computes its set from up_ghist and up_path, the values captured at prediction time. It does not use the values currently on the lookup port.
- R9: A lookup in the same cycle as an update sees the contents from before the update. The write is visible from the next cycle.
- R10: With history and path hashing disabled by parameter, the global history and path inputs have no effect on which entry a lookup finds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Branch PC being looked up |
| lk_ghist | input | GH_W | Current global direction history |
| lk_path | input | PATH_LEN*PC_W | Recent indirect targets, slot 0 (newest) in the low bits |
| lk_hit | output | 1 | Lookup found a matching way |
| lk_target | output | PC_W | Predicted target, or next sequential PC on a miss |
| up_valid | input | 1 | Write a corrected target this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_ghist | input | GH_W | Global history captured at prediction time |
| up_path | input | PATH_LEN*PC_W | Path vector captured at prediction time |
| up_target | input | PC_W | Corrected target |

## Verification
The checks assume that the update inputs are stable around the clock edge and that up_valid is a known level. They also assume that a lookup whose inputs repeat the previous cycle's update is asking for that branch. The stimulus changes inputs only on the falling edge and holds up_valid for exactly one rising edge. The sweeps use an eight-set, two-way configuration. The bench never predicts which way the LFSR picks. It judges allocation only by which of the written branches still hit, so random replacement never yields an expected value that depends on the LFSR's order.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Galois LFSR, maximal length polynomial
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    // Per-slot shift step for path folding
    function automatic int path_step(input int sets, input int plen);
        return (plen > 0) ? ($clog2(sets) / plen) : 0;
    endfunction

endpackage

// File: rtl/itc_index.sv
module itc_index #(
    parameter int PC_W      = 32,
    parameter int GH_W      = 16,
    parameter int SETS      = 256,
    parameter int TAG_W     = 16,
    parameter int PATH_LEN  = 3,
    parameter int SHIFT     = 2,
    parameter bit HASH_GH   = 1'b1,
    parameter bit HASH_PATH = 1'b1
) (
    input  logic [PC_W-1:0]          pc,
    input  logic [GH_W-1:0]          ghist,
    input  logic [PATH_LEN*PC_W-1:0] path,
    output logic [$clog2(SETS)-1:0]  idx,
    output logic [TAG_W-1:0]         tag
);
    localparam int IDX_W = $clog2(SETS);
    localparam int K     = itc_pkg::path_step(SETS, PATH_LEN);

    logic [PC_W-1:0] pc_sh;
    logic [PC_W-1:0] fold [PATH_LEN+1];

    assign pc_sh = pc >> SHIFT;

    generate
        if (HASH_GH) begin : g_gh
            logic [PC_W+GH_W-1:0] gh_ext;
            assign gh_ext  = {{PC_W{1'b0}}, ghist};
            assign fold[0] = pc_sh ^ gh_ext[PC_W-1:0];
        end else begin : g_nogh
            assign fold[0] = pc_sh;
        end

        for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
            if (HASH_PATH) begin : g_on
                assign fold[p+1] = fold[p] ^ (path[p*PC_W +: PC_W] >> (SHIFT + p*K));
            end else begin : g_off
                assign fold[p+1] = fold[p];
            end
        end
    endgenerate

    assign idx = fold[PATH_LEN][IDX_W-1:0];
    assign tag = pc_sh[TAG_W-1:0];

endmodule

// File: rtl/itc_lfsr.sv
module itc_lfsr (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step,
    output logic [itc_pkg::LFSR_W-1:0]  state
);
    always_ff @(posedge clk) begin
        if (rst)       state <= itc_pkg::LFSR_SEED;
        else if (step) state <= itc_pkg::lfsr_next(state);
    end

    // A zero state would freeze way selection
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/itc_store.sv
module itc_store #(
    parameter int SETS  = 256,
    parameter int WAYS  = 2,
    parameter int PC_W  = 32,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  logic [WAY_W-1:0] rnd_way,
    output logic             wr_alloc
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PC_W-1:0]  tgt_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    logic [WAYS-1:0]  rd_hitv;
    logic [WAYS-1:0]  wr_hitv;
    logic [WAY_W-1:0] wr_way;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign rd_hitv[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
            assign wr_hitv[w] = vld_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
        end
    endgenerate

    assign rd_hit   = |rd_hitv;
    assign wr_alloc = wr_en && !(|wr_hitv);

    always_comb begin
        rd_target = '0;
        for (int w = 0; w < WAYS; w++)
            if (rd_hitv[w]) rd_target = rd_target | tgt_q[rd_idx][w];
    end

    always_comb begin
        wr_way = rnd_way;
        for (int w = 0; w < WAYS; w++)
            if (wr_hitv[w]) wr_way = WAY_W'(w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
            tgt_q[wr_idx][wr_way] <= wr_target;
        end
    end

    // A tag lives in at most one way of a set
    assert_single_match_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_hitv) && $onehot0(wr_hitv));

endmodule

// File: rtl/ind_tgt_cache.sv
module ind_tgt_cache #(
    parameter int PC_W      = 32,
    parameter int GH_W      = 16,
    parameter int SETS      = 256,
    parameter int WAYS      = 2,
    parameter int TAG_W     = 16,
    parameter int PATH_LEN  = 3,
    parameter int SHIFT     = 2,
    parameter bit HASH_GH   = 1'b1,
    parameter bit HASH_PATH = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PC_W-1:0]          lk_pc,
    input  logic [GH_W-1:0]          lk_ghist,
    input  logic [PATH_LEN*PC_W-1:0] lk_path,
    output logic                     lk_hit,
    output logic [PC_W-1:0]          lk_target,
    input  logic                     up_valid,
    input  logic [PC_W-1:0]          up_pc,
    input  logic [GH_W-1:0]          up_ghist,
    input  logic [PATH_LEN*PC_W-1:0] up_path,
    input  logic [PC_W-1:0]          up_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << SHIFT;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             rd_hit, alloc;
    logic [PC_W-1:0]  rd_target;
    logic [itc_pkg::LFSR_W-1:0] lfsr_q;
    logic [WAY_W-1:0] rnd_way;

    itc_index #(.PC_W(PC_W), .GH_W(GH_W), .SETS(SETS), .TAG_W(TAG_W),
                .PATH_LEN(PATH_LEN), .SHIFT(SHIFT),
                .HASH_GH(HASH_GH), .HASH_PATH(HASH_PATH)) u_lk_hash (
        .pc(lk_pc), .ghist(lk_ghist), .path(lk_path), .idx(lk_idx), .tag(lk_tag));

    itc_index #(.PC_W(PC_W), .GH_W(GH_W), .SETS(SETS), .TAG_W(TAG_W),
                .PATH_LEN(PATH_LEN), .SHIFT(SHIFT),
                .HASH_GH(HASH_GH), .HASH_PATH(HASH_PATH)) u_up_hash (
        .pc(up_pc), .ghist(up_ghist), .path(up_path), .idx(up_idx), .tag(up_tag));

    itc_lfsr u_lfsr (.clk(clk), .rst(rst), .step(alloc), .state(lfsr_q));

    assign rnd_way = WAY_W'(lfsr_q % itc_pkg::LFSR_W'(WAYS));

    itc_store #(.SETS(SETS), .WAYS(WAYS), .PC_W(PC_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(rd_hit), .rd_target(rd_target),
        .wr_en(up_valid), .wr_idx(up_idx), .wr_tag(up_tag), .wr_target(up_target),
        .rnd_way(rnd_way), .wr_alloc(alloc));

    assign lk_hit    = rd_hit;
    assign lk_target = rd_hit ? rd_target : (lk_pc + STEP);

    // Nothing can hit right after reset
    assert_cold_miss_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // A branch written last cycle is found with the written target (R4, R9)
    assert_fill_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid) && lk_pc == $past(up_pc) &&
         lk_ghist == $past(up_ghist) && lk_path == $past(up_path))
        |-> (lk_hit && lk_target == $past(up_target)));

endmodule

// File: tb/tb_ind_tgt_cache.sv
`timescale 1ns/1ps
module tb_ind_tgt_cache;
    localparam int PC_W = 16, GH_W = 8, SETS = 8, WAYS = 2, TAG_W = 8, PLEN = 3, SH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
    logic [GH_W-1:0] lk_ghist = '0, up_ghist = '0;
    logic [PLEN*PC_W-1:0] lk_path = '0, up_path = '0;
    logic up_valid = 1'b0;
    logic lk_hit, pl_hit;
    logic [PC_W-1:0] lk_target, pl_target;

    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    ind_tgt_cache #(.PC_W(PC_W), .GH_W(GH_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
                    .PATH_LEN(PLEN), .SHIFT(SH)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_ghist(lk_ghist), .lk_path(lk_path),
        .lk_hit(lk_hit), .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc),
        .up_ghist(up_ghist), .up_path(up_path), .up_target(up_target));

    ind_tgt_cache #(.PC_W(PC_W), .GH_W(GH_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
                    .PATH_LEN(PLEN), .SHIFT(SH), .HASH_GH(1'b0), .HASH_PATH(1'b0)) dut_plain (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_ghist(lk_ghist), .lk_path(lk_path),
        .lk_hit(pl_hit), .lk_target(pl_target), .up_valid(up_valid), .up_pc(up_pc),
        .up_ghist(up_ghist), .up_path(up_path), .up_target(up_target));

    function automatic int exp_idx(input int pc, input int gh, input int p0, input int p1, input int p2);
        return ((pc >> 2) ^ gh ^ (p0 >> 2) ^ (p1 >> 3) ^ (p2 >> 4)) & 7;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int pc, input int gh, input int p0, input int p1, input int p2, input int tgt);
        @(negedge clk);
        up_pc = PC_W'(pc); up_ghist = GH_W'(gh);
        up_path = {PC_W'(p2), PC_W'(p1), PC_W'(p0)};
        up_target = PC_W'(tgt); up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic rd(input int pc, input int gh, input int p0, input int p1, input int p2);
        lk_pc = PC_W'(pc); lk_ghist = GH_W'(gh);
        lk_path = {PC_W'(p2), PC_W'(p1), PC_W'(p0)};
        #2;
    endtask

    initial begin : watchdog
        #4_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int cnt, prev, r0, r1;
        do_reset();

        // R1 / R5: everything misses after reset, including PC 0
        for (int i = 0; i < 64; i++) begin
            rd(i * 4, i, 0, 0, 0);
            chk("R1 cold miss", lk_hit, 0);
            chk("R5 fallthrough", lk_target, PC_W'(i * 4 + 4));
        end
        rd(16'hFFFC, 0, 0, 0, 0);
        chk("R5 wrap", lk_target, 16'h0000);

        // R4: one entry per set, tag equal to set
        for (int s = 0; s < 8; s++) wr(s * 4, 0, 0, 0, 0, 16'h1000 + s);
        @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            rd(s * 4, 0, 0, 0, 0);
            chk("R4 hit", lk_hit, 1);
            chk("R4 target", lk_target, 16'h1000 + s);
        end
        // R2: history and each path slot moves the set
        for (int g = 0; g < 16; g++) begin
            rd(0, g, 0, 0, 0);
            chk("R2 ghist index", lk_hit, ((g & 7) == 0));
        end
        for (int j = 0; j < 8; j++) begin
            rd(0, 0, j << 2, 0, 0); chk("R2 slot0 shift", lk_hit, (j == 0));
            rd(0, 0, 0, j << 3, 0); chk("R2 slot1 shift", lk_hit, (j == 0));
            rd(0, 0, 0, 0, j << 4); chk("R2 slot2 shift", lk_hit, (j == 0));
        end
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 4; b++) begin
                    rd(s * 4, a, b << 2, (a ^ b) << 3, b << 4);
                    chk("R2 combined fold", lk_hit, (exp_idx(s * 4, a, b << 2, (a ^ b) << 3, b << 4) == s));
                end

        // R3: aliasing on the tag; history is not in the tag
        rd(16'h0404, 0, 0, 0, 0);
        chk("R3 alias hit", lk_hit, 1);
        chk("R3 alias target", lk_target, 16'h1001);
        rd(16'h0024, 0, 0, 0, 0);
        chk("R3 other tag miss", lk_hit, 0);
        // R8: the update places the entry by its own captured history
        wr(16'h0100, 5, 0, 0, 0, 16'h2222);
        wr(16'h0100, 6, 0, 0, 0, 16'h3333);
        @(negedge clk);
        rd(16'h0100, 5, 0, 0, 0);
        chk("R8 captured history", lk_target, 16'h2222);
        rd(16'h0100, 6, 0, 0, 0);
        chk("R3 separate entry", lk_target, 16'h3333);
        rd(16'h0100, 0, 0, 0, 0);
        chk("R8 other history miss", lk_hit, 0);

        // R7: allocation into set 1 with distinct tags
        do_reset();
        prev = 0;
        for (int i = 0; i < 8; i++) begin
            wr((1 + 8 * i) * 4, 0, 0, 0, 0, 16'h4000 + i);
            @(negedge clk);
            rd((1 + 8 * i) * 4, 0, 0, 0, 0);
            chk("R7 new entry hits", lk_target, 16'h4000 + i);
            cnt = 0;
            for (int k = 0; k <= i; k++) begin
                rd((1 + 8 * k) * 4, 0, 0, 0, 0);
                if (lk_hit) cnt++;
            end
            chk("R7 set occupancy", (cnt >= 1 && cnt <= 2 && !(prev == 2 && cnt != 2)), 1);
            prev = cnt;
        end
        // R6: rewrite one resident, the other stays
        r0 = -1; r1 = -1;
        for (int k = 0; k < 8; k++) begin
            rd((1 + 8 * k) * 4, 0, 0, 0, 0);
            if (lk_hit) begin
                if (r0 < 0) r0 = k; else r1 = k;
            end
        end
        if (r0 >= 0) begin
            wr((1 + 8 * r0) * 4, 0, 0, 0, 0, 16'h5555);
            @(negedge clk);
            rd((1 + 8 * r0) * 4, 0, 0, 0, 0);
            chk("R6 target rewritten", lk_target, 16'h5555);
            if (r1 >= 0) begin
                rd((1 + 8 * r1) * 4, 0, 0, 0, 0);
                chk("R6 neighbour kept", lk_target, 16'h4000 + r1);
            end
        end else chk("R6 resident found", 0, 1);

        // R9: same-cycle update and lookup
        do_reset();
        @(negedge clk);
        up_pc = 16'h0008; up_ghist = '0; up_path = '0; up_target = 16'h6000; up_valid = 1'b1;
        rd(16'h0008, 0, 0, 0, 0);
        chk("R9 old contents", lk_hit, 0);
        @(negedge clk);
        up_valid = 1'b0;
        #2;
        chk("R9 visible next", lk_target, 16'h6000);
        @(negedge clk);
        up_target = 16'h6001; up_valid = 1'b1;
        #2;
        chk("R9 old target", lk_target, 16'h6000);
        @(negedge clk);
        up_valid = 1'b0;
        #2;
        chk("R9 new target", lk_target, 16'h6001);

        // R10: plain instance ignores history and path
        do_reset();
        wr(16'h000C, 16'h55, 16'h1234, 16'h5678, 16'h9ABC, 16'h7777);
        @(negedge clk);
        for (int g = 0; g < 256; g += 17) begin
            rd(16'h000C, g, g * 4, g * 8, g * 12);
            chk("R10 plain hit", {pl_hit, pl_target}, {1'b1, 16'h7777});
            chk("R2 hashed instance", lk_hit,
                (exp_idx(16'h000C, g, (g * 4) & 16'hFFFF, (g * 8) & 16'hFFFF, (g * 12) & 16'hFFFF) ==
                 exp_idx(16'h000C, 16'h55, 16'h1234, 16'h5678, 16'h9ABC)));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule